// File: doc/BRIEF.md
# Chained Start-on-Time-out Timer Array

This block is an array of timer modules joined in a fixed chain. Each module can run as one wide counter or be split into two independent halves, A and B. Every timer counts down from its load value to zero. In one-shot mode it then stops. In periodic mode it reloads and runs again. Each timer can be set to hold off until the timer ahead of it in the chain signals a time-out. With that setting, a single global start can launch a whole sequence of timed events.

The chain runs from module 0 upward. In a split module, half A feeds half B, and half B feeds half A of the next module. In a combined module, the wide timer feeds half A of the next module directly. Module 0's timer A takes its trigger from the last module, so the chain can close into a ring. A timer that is not set to wait starts on the global start and ignores its trigger input.

Top module: `trig_chain_timer_array`

## Requirements
- R1: A timer that is idle and not set to wait loads its value L when it samples `start_i` at clock edge k. Its time-out output is then high for one cycle, beginning at edge k+L+1.
- R2: A timer set to wait never starts on `start_i`. It stays idle until it samples its predecessor's time-out pulse. It loads at that edge, so its own time-out begins L+2 edges after the predecessor's pulse began.
- R3: With `split_i[i]`=1, half A of module i triggers half B of module i. Half B triggers half A of module i+1.
- R4: With `split_i[i]`=0, half A of module i counts the combined value {load_b, load_a}, with the load_b field as the upper HALF_W bits. Its time-out triggers half A of module i+1. Half B stays idle, with `run_b_o[i]` and `tmo_b_o[i]` held at 0.
- R5: Half A of module 0 takes its trigger from the last module's chain output. That output is half B's time-out when the last module is split, and half A's time-out when it is combined.
- R6: A one-shot timer (periodic bit 0) gives exactly one time-out pulse per launch. Its running flag is low in the cycle the pulse is high.
- R7: A periodic timer (periodic bit 1) reloads at time-out, keeps its running flag high, and pulses every L+1 cycles.
- R8: A waiting periodic timer needs only its first trigger. Later predecessor time-outs do not restart it while it runs.
- R9: A timer that is not set to wait ignores its predecessor's time-out.
- R10: While `rst_n` is low, all running flags and time-out outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Global start, sampled each clock |
| split_i | input | N_MOD | 1 = module split into halves A and B, 0 = one wide timer |
| wait_a_i | input | N_MOD | Half A waits for its chain trigger |
| wait_b_i | input | N_MOD | Half B waits for its chain trigger |
| periodic_a_i | input | N_MOD | Half A mode: 1 periodic, 0 one-shot |
| periodic_b_i | input | N_MOD | Half B mode: 1 periodic, 0 one-shot |
| load_a_i | input | N_MOD*HALF_W | Half A load values, module i at bits [i*HALF_W +: HALF_W] |
| load_b_i | input | N_MOD*HALF_W | Half B load values; upper bits of the combined load |
| tmo_a_o | output | N_MOD | Half A time-out pulses |
| tmo_b_o | output | N_MOD | Half B time-out pulses |
| run_a_o | output | N_MOD | Half A running flags |
| run_b_o | output | N_MOD | Half B running flags |

## Verification
The bench sweeps every split/combined pattern across three modules with several load sets, including zero and full-scale loads, and predicts each time-out cycle by adding L+2 per link. A design that routed a combined module's trigger to its own half B, or that started half B in combined mode, would show pulses at the wrong cycles or pulses on idle halves. A ring test with only the last half B free-running catches a design that does not feed module 0 from the last module. An all-waiting test catches a timer that wrongly starts on the global start. A periodic test with a fast predecessor and a slower waiting successor catches a successor that restarts on each trigger, because that shifts its pulse spacing. Loads of zero check the one-cycle count, and the sweep also shows that the non-waiting first timer ignores the pulse coming back around the ring.

// File: rtl/timer_chain_pkg.sv
package timer_chain_pkg;

  // Chain position that feeds half A of module idx; module 0 closes the ring.
  function automatic int pred_index(input int idx, input int n_mod);
    return (idx == 0) ? n_mod - 1 : idx - 1;
  endfunction

endpackage

// File: rtl/tca_counter.sv
module tca_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable_i,
  input  logic             periodic_i,
  input  logic             wait_i,
  input  logic             start_i,
  input  logic             trig_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             run_o,
  output logic             tmo_o
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             tmo_q, tmo_d;
  logic             launch;
  logic             cnt_en;

  // next-state logic
  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    tmo_d  = 1'b0;
    launch = enable_i && !run_q && (wait_i ? trig_i : start_i);
    if (!enable_i) begin
      run_d = 1'b0;
    end else if (run_q) begin
      if (cnt_q == '0) begin
        tmo_d = 1'b1;
        if (periodic_i) cnt_d = load_i;
        else            run_d = 1'b0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end else if (launch) begin
      run_d = 1'b1;
      cnt_d = load_i;
    end
  end

  assign cnt_en = run_q | launch;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      run_q <= run_d;
      tmo_q <= tmo_d;
    end
  end

  assign run_o = run_q;
  assign tmo_o = tmo_q;

  // R1: idle non-waiting timer launches on start
  a_r1_start_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && !wait_i && !run_o && start_i) |=> run_o);

  // R2: waiting idle timer stays idle without a trigger
  a_r2_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_i && !run_o && !trig_i) |=> !run_o);

  // R6: one-shot stops at its time-out, single-cycle pulse
  a_r6_oneshot_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_o && !periodic_i) |-> !run_o);
  a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_o && !periodic_i) |=> !tmo_o);

  // R7: periodic timer keeps running through a time-out
  a_r7_periodic_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_o && periodic_i) |-> run_o);

endmodule

// File: rtl/tca_module.sv
module tca_module #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              trig_i,
  input  logic              split_i,
  input  logic              wait_a_i,
  input  logic              wait_b_i,
  input  logic              periodic_a_i,
  input  logic              periodic_b_i,
  input  logic [HALF_W-1:0] load_a_i,
  input  logic [HALF_W-1:0] load_b_i,
  output logic              tmo_a_o,
  output logic              tmo_b_o,
  output logic              run_a_o,
  output logic              run_b_o,
  output logic              chain_o
);

  localparam int WIDE_W = 2 * HALF_W;

  logic [WIDE_W-1:0] load_a_eff;

  // R4: combined mode uses load_b as the upper half of the count
  assign load_a_eff = split_i ? {{HALF_W{1'b0}}, load_a_i} : {load_b_i, load_a_i};

  tca_counter #(.CNT_W(WIDE_W)) u_half_a (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (1'b1),
    .periodic_i (periodic_a_i),
    .wait_i     (wait_a_i),
    .start_i    (start_i),
    .trig_i     (trig_i),
    .load_i     (load_a_eff),
    .run_o      (run_a_o),
    .tmo_o      (tmo_a_o)
  );

  // R3: inside a split module, half A feeds half B
  tca_counter #(.CNT_W(HALF_W)) u_half_b (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (split_i),
    .periodic_i (periodic_b_i),
    .wait_i     (wait_b_i),
    .start_i    (start_i),
    .trig_i     (tmo_a_o),
    .load_i     (load_b_i),
    .run_o      (run_b_o),
    .tmo_o      (tmo_b_o)
  );

  assign chain_o = split_i ? tmo_b_o : tmo_a_o;

  // R3: split, waiting, idle half B starts after half A's time-out
  a_r3_a_feeds_b: assert property (@(posedge clk) disable iff (!rst_n)
    (split_i && wait_b_i && tmo_a_o && !run_b_o) |=> run_b_o);

  // R4: half B is idle in combined mode
  a_r4_b_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!split_i && $past(!split_i)) |-> (!run_b_o && !tmo_b_o));

endmodule

// File: rtl/trig_chain_timer_array.sv
module trig_chain_timer_array #(
  parameter int N_MOD  = 3,
  parameter int HALF_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic [N_MOD-1:0]         split_i,
  input  logic [N_MOD-1:0]         wait_a_i,
  input  logic [N_MOD-1:0]         wait_b_i,
  input  logic [N_MOD-1:0]         periodic_a_i,
  input  logic [N_MOD-1:0]         periodic_b_i,
  input  logic [N_MOD*HALF_W-1:0]  load_a_i,
  input  logic [N_MOD*HALF_W-1:0]  load_b_i,
  output logic [N_MOD-1:0]         tmo_a_o,
  output logic [N_MOD-1:0]         tmo_b_o,
  output logic [N_MOD-1:0]         run_a_o,
  output logic [N_MOD-1:0]         run_b_o
);

  logic [N_MOD-1:0] chain_out;
  logic [N_MOD-1:0] trig_in;

  for (genvar g = 0; g < N_MOD; g++) begin : g_mod
    // R5: module 0 takes the last module's chain output
    assign trig_in[g] = chain_out[timer_chain_pkg::pred_index(g, N_MOD)];

    tca_module #(.HALF_W(HALF_W)) u_mod (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .trig_i       (trig_in[g]),
      .split_i      (split_i[g]),
      .wait_a_i     (wait_a_i[g]),
      .wait_b_i     (wait_b_i[g]),
      .periodic_a_i (periodic_a_i[g]),
      .periodic_b_i (periodic_b_i[g]),
      .load_a_i     (load_a_i[g*HALF_W +: HALF_W]),
      .load_b_i     (load_b_i[g*HALF_W +: HALF_W]),
      .tmo_a_o      (tmo_a_o[g]),
      .tmo_b_o      (tmo_b_o[g]),
      .run_a_o      (run_a_o[g]),
      .run_b_o      (run_b_o[g]),
      .chain_o      (chain_out[g])
    );
  end

  // R5: ring closure, waiting idle module-0 A launches on the last module's output
  a_r5_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_a_i[0] && !run_a_o[0] && chain_out[N_MOD-1]) |=> run_a_o[0]);

endmodule

// File: tb/trig_chain_timer_array_tb_top.sv
module trig_chain_timer_array_tb_top;

  localparam int N  = 3;
  localparam int W  = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] split, wait_a, wait_b, per_a, per_b;
  logic [N*W-1:0] load_a, load_b;
  logic [N-1:0] tmo_a, tmo_b, run_a, run_b;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  int s0 = 0;
  int la[N], lb[N];
  int exp_a[N], exp_b[N];
  int first_a[N], first_b[N], cnt_a[N], cnt_b[N], runb_seen[N];
  int log_a0[4], log_b0[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_chain_timer_array #(.N_MOD(N), .HALF_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .split_i(split),
    .wait_a_i(wait_a), .wait_b_i(wait_b), .periodic_a_i(per_a), .periodic_b_i(per_b),
    .load_a_i(load_a), .load_b_i(load_b),
    .tmo_a_o(tmo_a), .tmo_b_o(tmo_b), .run_a_o(run_a), .run_b_o(run_b));

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        first_a[i] = -1; first_b[i] = -1; cnt_a[i] = 0; cnt_b[i] = 0; runb_seen[i] = 0;
      end
      for (int k = 0; k < 4; k++) begin log_a0[k] = -1; log_b0[k] = -1; end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (tmo_a[i]) begin
          if (first_a[i] < 0) first_a[i] = cyc;
          if (i == 0 && cnt_a[0] < 4) log_a0[cnt_a[0]] = cyc;
          cnt_a[i]++;
        end
        if (tmo_b[i]) begin
          if (first_b[i] < 0) first_b[i] = cyc;
          if (i == 0 && cnt_b[0] < 4) log_b0[cnt_b[0]] = cyc;
          cnt_b[i]++;
        end
        if (run_b[i]) runb_seen[i] = 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic apply_loads();
    for (int i = 0; i < N; i++) begin
      load_a[i*W +: W] = la[i][W-1:0];
      load_b[i*W +: W] = lb[i][W-1:0];
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    apply_loads();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    s0 = cyc + 1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic int a_eff(input int i);
    return split[i] ? la[i] : (lb[i] << W) + la[i];
  endfunction

  // Non-waiting A0 heads a chain where everyone else waits; each link adds L+2.
  task automatic predict_chain();
    int cur;
    cur = s0 + a_eff(0) + 1;
    for (int i = 0; i < N; i++) begin
      if (i > 0) cur = cur + a_eff(i) + 2;
      exp_a[i] = cur;
      if (split[i]) begin
        cur = cur + lb[i] + 2;
        exp_b[i] = cur;
      end else begin
        exp_b[i] = -1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    split = '1; wait_a = '0; wait_b = '0; per_a = '0; per_b = '0;
    for (int i = 0; i < N; i++) begin la[i] = 1; lb[i] = 1; end
    apply_loads();

    // R10: reset state
    repeat (2) @(negedge clk);
    check((tmo_a | tmo_b | run_a | run_b) == '0, "R10 reset outputs",
          int'({tmo_a, tmo_b, run_a, run_b}), 0);

    // R1 R3 R4 R6 R9: sweep every split pattern with two load sets
    for (int cfg = 0; cfg < (1 << N); cfg++) begin
      for (int set = 0; set < 2; set++) begin
        if (set == 0) begin
          la[0] = 0; la[1] = 3; la[2] = 1; lb[0] = 2; lb[1] = 0; lb[2] = 5;
        end else begin
          la[0] = 15; la[1] = 7; la[2] = 9; lb[0] = 1; lb[1] = 15; lb[2] = 0;
        end
        split = cfg[N-1:0];
        wait_a = {{(N-1){1'b1}}, 1'b0};
        wait_b = '1;
        per_a = '0; per_b = '0;
        do_reset();
        pulse_start();
        predict_chain();
        repeat (900) @(negedge clk);
        for (int i = 0; i < N; i++) begin
          check(first_a[i] == exp_a[i], i == 0 ? "R1 first A time-out" : "R3/R4 chained A time-out",
                first_a[i], exp_a[i]);
          check(cnt_a[i] == 1, "R6 one-shot A pulse count (R9 A0 ignores ring pulse)", cnt_a[i], 1);
          if (split[i]) begin
            check(first_b[i] == exp_b[i], "R3 B after A in split module", first_b[i], exp_b[i]);
            check(cnt_b[i] == 1, "R6 one-shot B pulse count", cnt_b[i], 1);
          end else begin
            check(cnt_b[i] == 0 && runb_seen[i] == 0, "R4 half B idle when combined",
                  cnt_b[i] + runb_seen[i], 0);
          end
          check(run_a[i] == 1'b0, "R6 one-shot A stopped", int'(run_a[i]), 0);
        end
      end
    end

    // R2: every timer waits, so start does nothing
    split = '1; wait_a = '1; wait_b = '1; per_a = '0; per_b = '0;
    la[0] = 1; la[1] = 2; la[2] = 3; lb[0] = 0; lb[1] = 1; lb[2] = 2;
    do_reset();
    pulse_start();
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if ((run_a | run_b | tmo_a | tmo_b) != '0) seen++;
      end
      check(seen == 0, "R2 waiting timers ignore start", seen, 0);
    end

    // R5 R9: ring, only the last half B runs free
    split = '1; wait_a = '1; wait_b = {1'b0, {(N-1){1'b1}}};
    la[0] = 2; la[1] = 1; la[2] = 3; lb[0] = 0; lb[1] = 4; lb[2] = 5;
    do_reset();
    pulse_start();
    repeat (60) @(negedge clk);
    check(first_b[2] == s0 + 6, "R1 free-running last B", first_b[2], s0 + 6);
    check(first_a[0] == s0 + 10, "R5 module 0 A follows last module", first_a[0], s0 + 10);
    check(first_b[0] == s0 + 12, "R3 module 0 B", first_b[0], s0 + 12);
    check(first_a[1] == s0 + 15, "R3 module 1 A", first_a[1], s0 + 15);
    check(first_a[2] == s0 + 26, "R3 module 2 A", first_a[2], s0 + 26);
    check(cnt_b[2] == 1, "R9 non-waiting last B ignores trigger", cnt_b[2], 1);

    // R5 with a combined last module: its A feeds module 0 A
    split = {1'b0, {(N-1){1'b1}}}; wait_a = {1'b0, {(N-1){1'b1}}}; wait_b = '1;
    la[0] = 2; la[1] = 1; la[2] = 3; lb[0] = 0; lb[1] = 4; lb[2] = 1;
    do_reset();
    pulse_start();
    repeat (80) @(negedge clk);
    check(first_a[2] == s0 + 20, "R4 combined last A count", first_a[2], s0 + 20);
    check(first_a[0] == s0 + 24, "R5 module 0 A follows combined last A", first_a[0], s0 + 24);

    // R7 R8: periodic A0 feeds slower periodic waiting B0
    split = '1; wait_a = {{(N-1){1'b1}}, 1'b0}; wait_b = '1; per_a = 3'b001; per_b = 3'b001;
    la[0] = 2; la[1] = 1; la[2] = 1; lb[0] = 4; lb[1] = 1; lb[2] = 1;
    do_reset();
    pulse_start();
    repeat (40) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      check(log_a0[k] == s0 + 3 + 3*k, "R7 periodic A0 spacing", log_a0[k], s0 + 3 + 3*k);
      check(log_b0[k] == s0 + 9 + 5*k, "R8 waiting periodic B0 not restarted", log_b0[k], s0 + 9 + 5*k);
    end
    check(run_a[0] == 1'b1 && run_b[0] == 1'b1, "R7 periodic timers keep running",
          int'({run_a[0], run_b[0]}), 3);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule